// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block turns a 48-bit virtual address into a physical address, using a small table of recent translations. The table is fully associative. Each slot holds a virtual page tag, a two-bit page-size code, a physical page number, five permission flags and an address-space identifier. Four page sizes are supported: 4 KiB, 2 MiB, 1 GiB and 512 GiB.

No hardware walks page tables. On a miss or a permission violation the block only reports the event, and trap software is expected to handle it. That software then installs the missing translation through an indexed write port, replacing whatever was in the chosen slot. It can also drop stale translations with a full flush or with a flush that targets one address space.

A lookup is presented for one cycle. The match, the priority pick and the permission check are combinational, and the outcome is registered, so it appears on the result port one cycle later.

Top module: `swtlb`

## Requirements
- R1: After reset every slot is absent and `rs_valid` is 0. A lookup made before any install reports a miss.
- R2: A lookup hits a 4 KiB slot when the 36 virtual page bits are equal and the slot is present. The physical address is then the slot's page number joined to virtual address bits [11:0].
- R3: Page-size code 0, 1, 2 or 3 means 4 KiB, 2 MiB, 1 GiB or 512 GiB. The code makes the match ignore the lowest 0, 9, 18 or 27 virtual page bits. Those same bits are taken from the virtual address, not from the stored page number, when the physical address is formed.
- R4: A slot qualifies only if its global flag (flags bit 4) is set or its stored ASID equals `lk_asid`.
- R5: A slot is present exactly when flags bits [2:0] (execute, write, read) are not all zero. A slot written with all three clear never matches.
- R6: Access kind 0 (read) needs flags bit 0. Kind 1 (write) needs flags bit 1. Kinds 2 and 3 (instruction fetch) need flags bit 2. A matching slot without the needed flag reports a fault.
- R7: A user-mode access (`lk_user`=1) to a slot whose user flag (flags bit 3) is clear faults. A supervisor access to a slot with the user flag set faults unless `lk_sum` is 1.
- R8: When several slots match, the lowest index decides the result and appears on `rs_idx`.
- R9: A write to slot `wr_idx` replaces all fields of that slot. The old translation there no longer matches.
- R10: A flush with `fl_all`=0 clears every non-global slot whose ASID equals `fl_asid`. Global slots and slots of other address spaces survive.
- R11: A flush with `fl_all`=1 clears every slot.
- R12: The result of a lookup appears exactly one cycle after it is presented, and uses the table state from before any write or flush in the same cycle. When a write and a flush occur in the same cycle, only the flush takes effect.
- R13: With `rs_valid`=1, exactly one of `rs_hit`, `rs_miss` and `rs_fault` is 1. `rs_paddr` is 0 unless `rs_hit` is 1. `rs_idx` is 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_kind | input | 2 | 0 read, 1 write, 2/3 instruction fetch |
| lk_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| lk_sum | input | 1 | Allows supervisor access to user pages |
| wr_en | input | 1 | Install a slot |
| wr_idx | input | IDX_W | Slot to overwrite |
| wr_vpn | input | 36 | Virtual page tag |
| wr_size | input | 2 | Page-size code |
| wr_ppn | input | PPN_W | Physical page number |
| wr_flags | input | 5 | {global, user, execute, write, read} |
| wr_asid | input | ASID_W | Owner ASID of the slot |
| fl_en | input | 1 | Flush request |
| fl_all | input | 1 | 1 clears all slots, 0 clears by ASID |
| fl_asid | input | ASID_W | ASID targeted by a selective flush |
| rs_valid | output | 1 | Registered result is valid |
| rs_hit | output | 1 | Permitted translation found |
| rs_miss | output | 1 | No qualifying slot |
| rs_fault | output | 1 | Slot matched but access denied |
| rs_paddr | output | PPN_W+12 | Translated physical address |
| rs_idx | output | IDX_W | Index of the deciding slot |

## Verification
A corrupted tag, size code or ASID in a slot shows at the ports one cycle after the next lookup that reaches it: as a miss where a hit was due, or as a wrong `rs_paddr`. A broken flag shows up as a wrong hit/fault choice or as a slot that never becomes present. A fault in the priority logic shows up as a wrong `rs_idx` whenever two slots overlap. Flush and overwrite faults stay hidden until a later lookup, so every table change in the bench is followed by lookups that reach both the changed slots and the ones that should be untouched.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int VA_W  = 48;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int LVL_W = 9;

  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_FETCH2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
  } flags_t;

  // ones where the tag must match; low bits of large pages cleared
  function automatic logic [VPN_W-1:0] tag_keep(input logic [1:0] sz);
    return {VPN_W{1'b1}} << (LVL_W * int'(sz));
  endfunction

  function automatic logic is_present(input flags_t f);
    return f.r | f.w | f.x;
  endfunction

  function automatic logic access_denied(input flags_t f, input acc_kind_e k,
                                         input logic user, input logic sum);
    logic grant;
    case (k)
      ACC_READ:  grant = f.r;
      ACC_WRITE: grant = f.w;
      default:   grant = f.x;
    endcase
    return !grant || (user && !f.u) || (!user && f.u && !sum);
  endfunction
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store
  import swtlb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int PPN_W  = 28,
  parameter int ASID_W = 16,
  parameter int IDX_W  = $clog2(N_ENT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [1:0]          wr_size,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  flags_t              wr_flags,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                fl_en,
  input  logic                fl_all,
  input  logic [ASID_W-1:0]   fl_asid,
  output logic [VPN_W-1:0]    e_vpn  [N_ENT],
  output logic [1:0]          e_size [N_ENT],
  output logic [PPN_W-1:0]    e_ppn  [N_ENT],
  output flags_t              e_flags[N_ENT],
  output logic [ASID_W-1:0]   e_asid [N_ENT],
  output logic [N_ENT-1:0]    ent_present
);
  for (genvar s = 0; s < N_ENT; s++) begin : g_slot
    logic flush_me;
    logic write_me;
    assign flush_me = fl_en && (fl_all || (!e_flags[s].g && e_asid[s] == fl_asid));
    assign write_me = wr_en && !fl_en && (wr_idx == IDX_W'(s));
    assign ent_present[s] = is_present(e_flags[s]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_vpn[s]   <= '0;
        e_size[s]  <= '0;
        e_ppn[s]   <= '0;
        e_flags[s] <= '0;
        e_asid[s]  <= '0;
      end else if (flush_me) begin
        e_flags[s] <= '0;
      end else if (write_me) begin
        e_vpn[s]   <= wr_vpn;
        e_size[s]  <= wr_size;
        e_ppn[s]   <= wr_ppn;
        e_flags[s] <= wr_flags;
        e_asid[s]  <= wr_asid;
      end
    end
  end
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match
  import swtlb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ASID_W = 16
) (
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  e_vpn  [N_ENT],
  input  logic [1:0]        e_size [N_ENT],
  input  flags_t            e_flags[N_ENT],
  input  logic [ASID_W-1:0] e_asid [N_ENT],
  input  logic [N_ENT-1:0]  ent_present,
  output logic [N_ENT-1:0]  hit_vec
);
  for (genvar s = 0; s < N_ENT; s++) begin : g_cmp
    logic tag_eq;
    logic owner_ok;
    assign tag_eq   = ((e_vpn[s] ^ lk_vpn) & tag_keep(e_size[s])) == '0;
    assign owner_ok = e_flags[s].g || (e_asid[s] == lk_asid);
    assign hit_vec[s] = ent_present[s] && tag_eq && owner_ok;
  end
endmodule

// File: rtl/swtlb_pick.sv
module swtlb_pick #(
  parameter int N_ENT = 8,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] hit_vec,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/swtlb.sv
module swtlb
  import swtlb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int PPN_W  = 28,
  parameter int ASID_W = 16,
  parameter int IDX_W  = $clog2(N_ENT),
  parameter int PA_W   = PPN_W + 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [47:0]       lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  input  logic              lk_user,
  input  logic              lk_sum,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [35:0]       wr_vpn,
  input  logic [1:0]        wr_size,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [4:0]        wr_flags,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              fl_en,
  input  logic              fl_all,
  input  logic [ASID_W-1:0] fl_asid,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_miss,
  output logic              rs_fault,
  output logic [PA_W-1:0]   rs_paddr,
  output logic [IDX_W-1:0]  rs_idx
);
  logic [VPN_W-1:0]  e_vpn  [N_ENT];
  logic [1:0]        e_size [N_ENT];
  logic [PPN_W-1:0]  e_ppn  [N_ENT];
  flags_t            e_flags[N_ENT];
  logic [ASID_W-1:0] e_asid [N_ENT];
  logic [N_ENT-1:0]  ent_present;
  logic [N_ENT-1:0]  hit_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic [VPN_W-1:0]  lk_vpn;
  logic              deny;
  logic [PPN_W-1:0]  keep_ppn;
  logic [PPN_W-1:0]  ppn_out;
  logic [PA_W-1:0]   pa_next;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  swtlb_store #(.N_ENT(N_ENT), .PPN_W(PPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_size(wr_size),
    .wr_ppn(wr_ppn), .wr_flags(flags_t'(wr_flags)), .wr_asid(wr_asid),
    .fl_en(fl_en), .fl_all(fl_all), .fl_asid(fl_asid),
    .e_vpn(e_vpn), .e_size(e_size), .e_ppn(e_ppn), .e_flags(e_flags),
    .e_asid(e_asid), .ent_present(ent_present)
  );

  swtlb_match #(.N_ENT(N_ENT), .ASID_W(ASID_W)) u_match (
    .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .e_vpn(e_vpn), .e_size(e_size), .e_flags(e_flags), .e_asid(e_asid),
    .ent_present(ent_present), .hit_vec(hit_vec)
  );

  swtlb_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  // large pages: low page bits come from the virtual address
  assign deny     = access_denied(e_flags[win_idx], acc_kind_e'(lk_kind), lk_user, lk_sum);
  assign keep_ppn = PPN_W'(tag_keep(e_size[win_idx]));
  assign ppn_out  = (e_ppn[win_idx] & keep_ppn) | (PPN_W'(lk_vpn) & ~keep_ppn);
  assign pa_next  = {ppn_out, lk_vaddr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_fault <= 1'b0;
      rs_paddr <= '0;
      rs_idx   <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && any_hit && !deny;
      rs_miss  <= lk_valid && !any_hit;
      rs_fault <= lk_valid && any_hit && deny;
      rs_paddr <= (lk_valid && any_hit && !deny) ? pa_next : '0;
      rs_idx   <= (lk_valid && any_hit) ? win_idx : '0;
    end
  end
endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk #(
  parameter int N_ENT = 8,
  parameter int IDX_W = 3,
  parameter int PA_W  = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             fl_en,
  input logic             fl_all,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic             rs_miss,
  input logic             rs_fault,
  input logic [PA_W-1:0]  rs_paddr,
  input logic [IDX_W-1:0] rs_idx,
  input logic [N_ENT-1:0] ent_present,
  input logic [N_ENT-1:0] hit_vec,
  input logic             any_hit,
  input logic [IDX_W-1:0] win_idx
);
  logic [N_ENT-1:0] below_win;
  assign below_win = (N_ENT'(1) << win_idx) - N_ENT'(1);

  // R12
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  // R12
  no_result_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  // R13
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault}));
  // R13
  idle_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !(rs_hit || rs_miss || rs_fault));
  // R13
  paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_hit |-> rs_paddr == '0);
  // R13
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> rs_idx == '0);
  // R11
  full_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && fl_all) |=> ent_present == '0);
  // R1
  empty_table_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && ent_present == '0) |=> rs_miss);
  // R5
  hit_needs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~ent_present) == '0);
  // R8
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[win_idx] && (hit_vec & below_win) == '0));
endmodule

bind swtlb swtlb_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fl_en(fl_en), .fl_all(fl_all),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
  .rs_paddr(rs_paddr), .rs_idx(rs_idx), .ent_present(ent_present),
  .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
);

// File: tb/swtlb_tb.sv
`timescale 1ns/1ps
module swtlb_tb;
  localparam int N = 8;
  localparam int PPN_W = 28;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int PA_W = PPN_W + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0; logic [47:0] lk_vaddr = '0; logic [AW-1:0] lk_asid = '0;
  logic [1:0] lk_kind = '0; logic lk_user = 0; logic lk_sum = 0;
  logic wr_en = 0; logic [IW-1:0] wr_idx = '0; logic [35:0] wr_vpn = '0;
  logic [1:0] wr_size = '0; logic [PPN_W-1:0] wr_ppn = '0; logic [4:0] wr_flags = '0;
  logic [AW-1:0] wr_asid = '0; logic fl_en = 0; logic fl_all = 0; logic [AW-1:0] fl_asid = '0;
  logic rs_valid, rs_hit, rs_miss, rs_fault;
  logic [PA_W-1:0] rs_paddr;
  logic [IW-1:0] rs_idx;

  int vectors = 0;
  int miscompares = 0;

  // reference table, written from the stimulus only
  logic [35:0] m_vpn [N];
  logic [1:0]  m_size[N];
  logic [PPN_W-1:0] m_ppn[N];
  logic [4:0]  m_flags[N];
  logic [AW-1:0] m_asid[N];

  always #2.5 clk = ~clk;

  swtlb #(.N_ENT(N), .PPN_W(PPN_W), .ASID_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_kind(lk_kind), .lk_user(lk_user), .lk_sum(lk_sum), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_size(wr_size), .wr_ppn(wr_ppn), .wr_flags(wr_flags),
    .wr_asid(wr_asid), .fl_en(fl_en), .fl_all(fl_all), .fl_asid(fl_asid),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
    .rs_paddr(rs_paddr), .rs_idx(rs_idx)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected outcome restated with shifts over page-offset widths
  task automatic ref_look(input logic [47:0] va, input logic [AW-1:0] la, input logic [1:0] kd,
                          input bit us, input bit sm, output bit h, output bit m, output bit f,
                          output logic [63:0] pa, output int ix);
    int found = -1;
    for (int i = 0; i < N; i++) begin
      int sh = 9 * int'(m_size[i]);
      bit pres = m_flags[i][2:0] != 3'b000;
      bit tag = (64'(va[47:12]) >> sh) == (64'(m_vpn[i]) >> sh);
      bit own = m_flags[i][4] || (m_asid[i] == la);
      if (found < 0 && pres && tag && own) found = i;
    end
    h = 0; m = 0; f = 0; pa = 0; ix = 0;
    if (found < 0) m = 1;
    else begin
      int off = 12 + 9 * int'(m_size[found]);
      logic [63:0] pm = (64'(1) << off) - 64'(1);
      bit need = (kd == 2'd0) ? m_flags[found][0] : (kd == 2'd1) ? m_flags[found][1] : m_flags[found][2];
      bit bad = !need || (us && !m_flags[found][3]) || (!us && m_flags[found][3] && !sm);
      ix = found;
      if (bad) f = 1;
      else begin
        h = 1;
        pa = ((64'(m_ppn[found]) << 12) & ~pm) | (64'(va) & pm);
        pa = pa & ((64'(1) << PA_W) - 64'(1));
      end
    end
  endtask

  // one cycle of stimulus; entered and left at a falling edge
  task automatic step(bit dl, logic [47:0] va, logic [AW-1:0] la, logic [1:0] kd, bit us, bit sm,
                      bit dw, int wi, logic [35:0] wv, logic [1:0] ws, logic [PPN_W-1:0] wp,
                      logic [4:0] wf, logic [AW-1:0] wa, bit df, bit fa, logic [AW-1:0] fs,
                      string req);
    bit eh, em, ef; logic [63:0] epa; int eix;
    ref_look(va, la, kd, us, sm, eh, em, ef, epa, eix);
    lk_valid = dl; lk_vaddr = va; lk_asid = la; lk_kind = kd; lk_user = us; lk_sum = sm;
    wr_en = dw; wr_idx = IW'(wi); wr_vpn = wv; wr_size = ws; wr_ppn = wp; wr_flags = wf; wr_asid = wa;
    fl_en = df; fl_all = fa; fl_asid = fs;
    if (df) begin
      for (int i = 0; i < N; i++)
        if (fa || (!m_flags[i][4] && m_asid[i] == fs)) m_flags[i] = '0;
    end else if (dw) begin
      m_vpn[wi] = wv; m_size[wi] = ws; m_ppn[wi] = wp; m_flags[wi] = wf; m_asid[wi] = wa;
    end
    @(negedge clk);
    lk_valid = 0; wr_en = 0; fl_en = 0;
    if (dl) begin
      check(req, "valid", 64'(rs_valid), 1);
      check(req, "hit", 64'(rs_hit), 64'(eh));
      check(req, "miss", 64'(rs_miss), 64'(em));
      check(req, "fault", 64'(rs_fault), 64'(ef));
      check(req, "paddr", 64'(rs_paddr), epa);
      check(req, "idx", 64'(rs_idx), 64'(eix));
    end else begin
      check(req, "idle valid", 64'(rs_valid), 0);
    end
  endtask

  task automatic look(logic [47:0] va, logic [AW-1:0] la, logic [1:0] kd, bit us, bit sm, string req);
    step(1, va, la, kd, us, sm, 0, 0, '0, '0, '0, '0, '0, 0, 0, '0, req);
  endtask

  task automatic put(int wi, logic [35:0] wv, logic [1:0] ws, logic [PPN_W-1:0] wp,
                     logic [4:0] wf, logic [AW-1:0] wa, string req);
    step(0, '0, '0, 0, 0, 0, 1, wi, wv, ws, wp, wf, wa, 0, 0, '0, req);
  endtask

  task automatic flush(bit fa, logic [AW-1:0] fs, string req);
    step(0, '0, '0, 0, 0, 0, 0, 0, '0, '0, '0, '0, '0, 1, fa, fs, req);
  endtask

  // R1: reset state and empty-table miss
  task automatic t_reset();
    check("R1", "valid after reset", 64'(rs_valid), 0);
    check("R1", "hit after reset", 64'(rs_hit), 0);
    look(48'h1234_5678_9ABC, 16'd5, 2'd0, 0, 0, "R1");
  endtask

  // R2: 4 KiB translation
  task automatic t_small();
    put(2, 36'h0_1234_5678, 2'd0, 28'h0AB_CDEF, 5'b00111, 16'd5, "R2");
    look({36'h0_1234_5678, 12'h9A4}, 16'd5, 2'd0, 0, 0, "R2");
    look({36'h0_1234_5678, 12'hFFF}, 16'd5, 2'd1, 0, 0, "R2");
    look({36'h0_1234_5679, 12'h000}, 16'd5, 2'd0, 0, 0, "R2");
  endtask

  // R3: the three large page sizes
  task automatic t_large();
    put(3, 36'h0_AAAA_A000, 2'd1, 28'h123_4000, 5'b10111, 16'd0, "R3");
    put(4, 36'h1_5554_0000, 2'd2, 28'h0C0_0000, 5'b10111, 16'd0, "R3");
    put(5, 36'h7_F800_0000, 2'd3, 28'h800_0000, 5'b10111, 16'd0, "R3");
    look({36'h0_AAAA_A1FF, 12'h321}, 16'd9, 2'd0, 0, 0, "R3");
    look({36'h0_AAAA_A200, 12'h321}, 16'd9, 2'd0, 0, 0, "R3");
    look({36'h1_5557_FFFF, 12'h777}, 16'd9, 2'd2, 0, 0, "R3");
    look({36'h7_FFFF_FFFF, 12'hABC}, 16'd9, 2'd1, 0, 0, "R3");
    look({36'h7_F812_3456, 12'h001}, 16'd9, 2'd0, 0, 0, "R3");
  endtask

  // R4: ASID qualification and global pages
  task automatic t_asid();
    look({36'h0_1234_5678, 12'h010}, 16'd6, 2'd0, 0, 0, "R4");
    look({36'h0_AAAA_A000, 12'h010}, 16'hBEEF, 2'd0, 0, 0, "R4");
  endtask

  // R5: no R/W/X means absent
  task automatic t_present();
    put(6, 36'h0_0000_0042, 2'd0, 28'h1, 5'b11000, 16'd5, "R5");
    look({36'h0_0000_0042, 12'h0}, 16'd5, 2'd0, 0, 0, "R5");
    look({36'h0_0000_0042, 12'h0}, 16'd5, 2'd2, 1, 0, "R5");
  endtask

  // R6: permission by access kind
  task automatic t_perm();
    put(7, 36'h0_0000_0100, 2'd0, 28'h55, 5'b00001, 16'd5, "R6");
    look({36'h0_0000_0100, 12'h4}, 16'd5, 2'd0, 0, 0, "R6");
    look({36'h0_0000_0100, 12'h4}, 16'd5, 2'd1, 0, 0, "R6");
    look({36'h0_0000_0100, 12'h4}, 16'd5, 2'd2, 0, 0, "R6");
    put(7, 36'h0_0000_0100, 2'd0, 28'h55, 5'b00100, 16'd5, "R6");
    look({36'h0_0000_0100, 12'h4}, 16'd5, 2'd3, 0, 0, "R6");
    look({36'h0_0000_0100, 12'h4}, 16'd5, 2'd0, 0, 0, "R6");
  endtask

  // R7: user flag and supervisor access to user pages
  task automatic t_user();
    put(7, 36'h0_0000_0200, 2'd0, 28'h66, 5'b01011, 16'd5, "R7");
    look({36'h0_0000_0200, 12'h8}, 16'd5, 2'd0, 0, 0, "R7");
    look({36'h0_0000_0200, 12'h8}, 16'd5, 2'd0, 0, 1, "R7");
    look({36'h0_0000_0200, 12'h8}, 16'd5, 2'd1, 1, 0, "R7");
    look({36'h0_1234_5678, 12'h8}, 16'd5, 2'd0, 1, 0, "R7");
  endtask

  // R8/R9: overlapping slots and overwrite
  task automatic t_prio();
    put(1, 36'h0_0000_0300, 2'd0, 28'h111, 5'b00011, 16'd5, "R8");
    put(6, 36'h0_0000_0300, 2'd0, 28'h666, 5'b00011, 16'd5, "R8");
    look({36'h0_0000_0300, 12'h10}, 16'd5, 2'd0, 0, 0, "R8");
    put(1, 36'h0_0000_0301, 2'd0, 28'h222, 5'b00011, 16'd5, "R9");
    look({36'h0_0000_0300, 12'h10}, 16'd5, 2'd0, 0, 0, "R9");
    look({36'h0_0000_0301, 12'h10}, 16'd5, 2'd0, 0, 0, "R9");
  endtask

  // R10: selective flush
  task automatic t_flush_asid();
    put(0, 36'h0_0000_0A00, 2'd0, 28'hA, 5'b00011, 16'd7, "R10");
    put(1, 36'h0_0000_0B00, 2'd0, 28'hB, 5'b10011, 16'd7, "R10");
    put(2, 36'h0_0000_0C00, 2'd0, 28'hC, 5'b00011, 16'd8, "R10");
    flush(0, 16'd7, "R10");
    look({36'h0_0000_0A00, 12'h0}, 16'd7, 2'd0, 0, 0, "R10");
    look({36'h0_0000_0B00, 12'h0}, 16'd7, 2'd0, 0, 0, "R10");
    look({36'h0_0000_0C00, 12'h0}, 16'd8, 2'd0, 0, 0, "R10");
  endtask

  // R11: full flush
  task automatic t_flush_all();
    flush(1, '0, "R11");
    look({36'h0_0000_0B00, 12'h0}, 16'd7, 2'd0, 0, 0, "R11");
    look({36'h0_0000_0C00, 12'h0}, 16'd8, 2'd0, 0, 0, "R11");
    look({36'h7_F800_0000, 12'h0}, 16'd0, 2'd0, 0, 0, "R11");
  endtask

  // R12: same-cycle ordering
  task automatic t_order();
    put(0, 36'h0_0000_0D00, 2'd0, 28'hD, 5'b00011, 16'd1, "R12");
    step(1, {36'h0_0000_0D00, 12'h5}, 16'd1, 2'd0, 0, 0,
         1, 0, 36'h0_0000_0E00, 2'd0, 28'hE, 5'b00011, 16'd1, 0, 0, '0, "R12");
    look({36'h0_0000_0D00, 12'h5}, 16'd1, 2'd0, 0, 0, "R12");
    look({36'h0_0000_0E00, 12'h5}, 16'd1, 2'd0, 0, 0, "R12");
    step(0, '0, '0, 0, 0, 0, 1, 3, 36'h0_0000_0F00, 2'd0, 28'hF, 5'b00011, 16'd1, 1, 1, '0, "R12");
    look({36'h0_0000_0F00, 12'h5}, 16'd1, 2'd0, 0, 0, "R12");
    look({36'h0_0000_0E00, 12'h5}, 16'd1, 2'd0, 0, 0, "R12");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_size[i] = '0; m_ppn[i] = '0; m_flags[i] = '0; m_asid[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_asid();
    t_present();
    t_perm();
    t_user();
    t_prio();
    t_flush_asid();
    t_flush_all();
    t_order();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule